// File: doc/BRIEF.md
# Virtualized Coarse-Grain Pipeline Array

This block is a small coarse-grain reconfigurable datapath. It runs an application pipeline that has more virtual stages than the array has physical stripes. Each stripe is a row of byte-wide processing elements. Each element has an ALU and a two-entry register file. A configuration store holds one configuration word per virtual stage. Once a pass starts, a sequencer copies the next stage's word into one stripe each cycle. It walks through the stripes in rotation, so a stage that does not fit overwrites the stripe that holds the oldest stage.

A stage executes in the cycle after it is loaded. Its four output bytes are kept in that stripe's pipeline register, and the next stage reads them from there. Stage 0 takes its operands from the input word instead. The operands for the executing stripe arrive on one shared operand bus. The result of the last stage is presented with a single-cycle valid pulse. Software writes the stage configurations while the array is idle. The upstream source then offers a word with a valid/ready handshake.

Top module: `vpipe_array`

## Requirements
- R1: Reset is asynchronous and active low. After reset, in_ready and out_valid are low and out_data is zero. Every stage configuration is all zeros (ADD, both operands from the previous output), and every register holds zero.
- R2: A write with cfg_we high stores cfg_data as the configuration of stage cfg_addr if the array is idle at that edge. A write made while a pass is in progress is ignored.
- R3: in_valid high while idle starts a pass, and stage 0 is loaded in the next cycle. in_ready is high in the cycle after that, and in_data is taken at the edge where in_valid and in_ready are both high. While in_valid is low in that cycle, in_ready stays high and no stage advances.
- R4: Opcodes are 0 add, 1 subtract (A-B), 2 and, 3 or, 4 xor, 5 shift A left by B[2:0], 6 shift A right logically by B[2:0], 7 pass A. All results wrap at 8 bits.
- R5: Element i uses configuration bits [7i+6:7i]. Bits [2:0] are the opcode. Bit 3 selects operand A: 0 takes lane i of the previous output, 1 takes the selected register. Bit 4 selects operand B: 0 takes lane (i+1) mod 4 of the previous output, 1 takes the selected register. Bit 5 selects the register and bit 6 is the register write enable. Lane i of a word is bits [8i+7:8i].
- R6: With the write enable set, the ALU result is stored in the selected register at the end of the execution cycle. Registers keep their value across passes and reconfigurations and change only through such a write.
- R7: Virtual stage k is configured into stripe k mod 3 one cycle before it executes. Registers belong to the physical stripe, so stage 3 sees what stage 0 wrote.
- R8: out_valid rises at the fourth clock edge after the edge that accepts a word and stays high for exactly one cycle. out_data carries the stage-4 result in that cycle and is zero otherwise.
- R9: The operands of stage k > 0 come from the output of stage k-1 in the same pass. Stage 0 reads in_data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word offered; also starts a pass while idle |
| in_ready | output | 1 | High while stage 0 is executing and can take the word |
| in_data | input | 32 | Four input lanes of 8 bits |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Virtual stage index to write (0..4) |
| cfg_data | input | 28 | Configuration word, 7 bits per element |
| out_valid | output | 1 | One-cycle pulse marking a result |
| out_data | output | 32 | Stage-4 result lanes |

## Verification
The register-write property assumes that a stripe's configuration does not change in the cycle after it executes. This holds because a stripe is reloaded only three loads later. The handshake properties assume that a source which raised in_valid to start a pass may drop it and raise it again later, and they place no limit on how long it stays low. The bench only writes stage indices 0 to 4. It makes one of its configuration writes while a pass is running, and it holds in_valid low for several cycles during one run to exercise the stall.

// File: rtl/vpa_pkg.sv
package vpa_pkg;
  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_SHL  = 3'd5,
    OP_SHR  = 3'd6,
    OP_PASS = 3'd7
  } vpa_op_e;
endpackage

// File: rtl/vpa_cfg_store.sv
module vpa_cfg_store #(
  parameter int NSTAGE = 5,
  parameter int CW     = 28,
  localparam int AW    = $clog2(NSTAGE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_allow,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_data
);
  logic [NSTAGE-1:0][CW-1:0] mem_q, mem_d;

  always_comb begin
    mem_d = mem_q;
    if (wr_en && wr_allow && (int'(wr_addr) < NSTAGE)) begin
      mem_d[wr_addr] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else        mem_q <= mem_d;
  end

  assign rd_data = mem_q[rd_addr];

  // R2: a write attempted during a pass leaves the store untouched
  assert_busy_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_allow) |=> $stable(mem_q));
endmodule

// File: rtl/vpa_seq.sv
module vpa_seq #(
  parameter int NSTAGE  = 5,
  parameter int NSTRIPE = 3,
  localparam int AW     = $clog2(NSTAGE),
  localparam int SAW    = $clog2(NSTAGE + 1),
  localparam int PW     = $clog2(NSTRIPE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          busy,
  output logic          in_ready,
  output logic          load_en,
  output logic [AW-1:0] load_stage,
  output logic [PW-1:0] load_ptr,
  output logic          exec_en,
  output logic [PW-1:0] exec_ptr,
  output logic [PW-1:0] src_ptr,
  output logic          first_exec,
  output logic          done
);
  logic           run_q, run_d;
  logic [SAW-1:0] step_q, step_d;
  logic [PW-1:0]  ldp_q, ldp_d, exp_q, exp_d, srcp_q, srcp_d;
  logic           done_q, done_d;
  logic           advance;

  assign advance = run_q && ((step_q != SAW'(1)) || in_valid);

  always_comb begin
    run_d  = run_q;
    step_d = step_q;
    ldp_d  = ldp_q;
    exp_d  = exp_q;
    srcp_d = srcp_q;
    done_d = 1'b0;
    if (!run_q) begin
      if (in_valid) begin
        run_d  = 1'b1;
        step_d = '0;
        ldp_d  = '0;
      end
    end else if (advance) begin
      step_d = step_q + SAW'(1);
      ldp_d  = (ldp_q == PW'(NSTRIPE - 1)) ? '0 : ldp_q + PW'(1);
      exp_d  = ldp_q;
      srcp_d = exp_q;
      if (step_q == SAW'(NSTAGE)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      step_q <= '0;
      ldp_q  <= '0;
      exp_q  <= '0;
      srcp_q <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      step_q <= step_d;
      ldp_q  <= ldp_d;
      exp_q  <= exp_d;
      srcp_q <= srcp_d;
      done_q <= done_d;
    end
  end

  assign busy       = run_q;
  assign in_ready   = run_q && (step_q == SAW'(1));
  assign first_exec = (step_q == SAW'(1));
  assign load_en    = advance && (step_q < SAW'(NSTAGE));
  assign load_stage = AW'(step_q);
  assign load_ptr   = ldp_q;
  assign exec_en    = advance && (step_q != '0);
  assign exec_ptr   = exp_q;
  assign src_ptr    = srcp_q;
  assign done       = done_q;

  // R3: ready is held while the source has no word
  assert_stall_holds_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready);
  // R3: an accepted word moves the pass on
  assert_accept_moves_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |=> !in_ready);
  // R8: result valid is a single-cycle pulse
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/vpa_pe.sv
module vpa_pe
  import vpa_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 2,
  localparam int RSW = $clog2(NREG),
  localparam int CFW = OPW + RSW + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           exec_en,
  input  logic [CFW-1:0] cfg,
  input  logic [DW-1:0]  lane_a,
  input  logic [DW-1:0]  lane_b,
  output logic [DW-1:0]  res_q
);
  localparam int SHW = $clog2(DW);

  vpa_op_e                  op;
  logic                     sel_a, sel_b, wr;
  logic [RSW-1:0]           rsel;
  logic [NREG-1:0][DW-1:0]  rf_q, rf_d;
  logic [DW-1:0]            rd_val, opa, opb, alu, res_d;

  always_comb begin
    op     = vpa_op_e'(cfg[OPW-1:0]);
    sel_a  = cfg[OPW];
    sel_b  = cfg[OPW+1];
    rsel   = cfg[OPW+2 +: RSW];
    wr     = cfg[OPW+2+RSW];
    rd_val = rf_q[rsel];
    opa    = sel_a ? rd_val : lane_a;
    opb    = sel_b ? rd_val : lane_b;
    case (op)
      OP_ADD:  alu = opa + opb;
      OP_SUB:  alu = opa - opb;
      OP_AND:  alu = opa & opb;
      OP_OR:   alu = opa | opb;
      OP_XOR:  alu = opa ^ opb;
      OP_SHL:  alu = opa << opb[SHW-1:0];
      OP_SHR:  alu = opa >> opb[SHW-1:0];
      default: alu = opa;
    endcase
  end

  always_comb begin
    res_d = exec_en ? alu : res_q;
    rf_d  = rf_q;
    if (exec_en && wr) rf_d[rsel] = alu;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      rf_q  <= '0;
    end else begin
      res_q <= res_d;
      rf_q  <= rf_d;
    end
  end

  // R6: an enabled write leaves the ALU result in the selected register
  assert_reg_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && wr) |=> (rf_q[$past(rsel)] == $past(alu)));
endmodule

// File: rtl/vpa_stripe.sv
module vpa_stripe
  import vpa_pkg::*;
#(
  parameter int NPE  = 4,
  parameter int DW   = 8,
  parameter int NREG = 2,
  localparam int RSW = $clog2(NREG),
  localparam int CFW = OPW + RSW + 3,
  localparam int SW  = NPE * CFW,
  localparam int LW  = NPE * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [SW-1:0] cfg_in,
  input  logic          exec_en,
  input  logic [LW-1:0] opnd,
  output logic [LW-1:0] res
);
  logic [SW-1:0] cfg_q, cfg_d;

  assign cfg_d = load_en ? cfg_in : cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  for (genvar g = 0; g < NPE; g++) begin : g_pe
    localparam int NB = (g + 1) % NPE;
    vpa_pe #(.DW(DW), .NREG(NREG)) u_pe (
      .clk     (clk),
      .rst_n   (rst_n),
      .exec_en (exec_en),
      .cfg     (cfg_q[g*CFW +: CFW]),
      .lane_a  (opnd[g*DW +: DW]),
      .lane_b  (opnd[NB*DW +: DW]),
      .res_q   (res[g*DW +: DW])
    );
  end

  // R7: a stripe never executes in the cycle it is being reconfigured
  assert_no_exec_while_loading_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_en && exec_en));
endmodule

// File: rtl/vpipe_array.sv
module vpipe_array
  import vpa_pkg::*;
#(
  parameter int NSTAGE  = 5,
  parameter int NSTRIPE = 3,
  parameter int NPE     = 4,
  parameter int DW      = 8,
  parameter int NREG    = 2,
  localparam int RSW    = $clog2(NREG),
  localparam int CFW    = OPW + RSW + 3,
  localparam int CW     = NPE * CFW,
  localparam int LW     = NPE * DW,
  localparam int AW     = $clog2(NSTAGE),
  localparam int PW     = $clog2(NSTRIPE),
  localparam int LAST   = (NSTAGE - 1) % NSTRIPE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [LW-1:0] in_data,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_data,
  output logic          out_valid,
  output logic [LW-1:0] out_data
);
  logic                         busy, first_exec, ld_en, ex_en;
  logic [AW-1:0]                ld_stage;
  logic [PW-1:0]                ld_ptr, ex_ptr, src_ptr;
  logic [CW-1:0]                rd_cfg;
  logic [NSTRIPE-1:0]           load_vec, exec_vec;
  logic [NSTRIPE-1:0][LW-1:0]   res_w;
  logic [LW-1:0]                opnd_bus;

  vpa_seq #(.NSTAGE(NSTAGE), .NSTRIPE(NSTRIPE)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .busy       (busy),
    .in_ready   (in_ready),
    .load_en    (ld_en),
    .load_stage (ld_stage),
    .load_ptr   (ld_ptr),
    .exec_en    (ex_en),
    .exec_ptr   (ex_ptr),
    .src_ptr    (src_ptr),
    .first_exec (first_exec),
    .done       (out_valid)
  );

  vpa_cfg_store #(.NSTAGE(NSTAGE), .CW(CW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_allow (!busy),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_data),
    .rd_addr  (ld_stage),
    .rd_data  (rd_cfg)
  );

  always_comb begin
    for (int p = 0; p < NSTRIPE; p++) begin
      load_vec[p] = ld_en && (ld_ptr == PW'(p));
      exec_vec[p] = ex_en && (ex_ptr == PW'(p));
    end
  end

  assign opnd_bus = first_exec ? in_data : res_w[src_ptr];

  for (genvar g = 0; g < NSTRIPE; g++) begin : g_stripe
    vpa_stripe #(.NPE(NPE), .DW(DW), .NREG(NREG)) u_stripe (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (load_vec[g]),
      .cfg_in  (rd_cfg),
      .exec_en (exec_vec[g]),
      .opnd    (opnd_bus),
      .res     (res_w[g])
    );
  end

  assign out_data = out_valid ? res_w[LAST] : '0;

  // R8: a result is only flagged right after the last stage's stripe executed
  assert_out_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(exec_vec[LAST]));
  // R7: at most one stripe is reconfigured per cycle
  assert_one_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_vec));
endmodule

// File: tb/tb_vpipe_array.sv
module tb_vpipe_array;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, in_valid, cfg_we;
  logic [31:0] in_data;
  logic [2:0]  cfg_addr;
  logic [27:0] cfg_data;
  logic        in_ready, out_valid;
  logic [31:0] out_data;

  int tests = 0;
  int fails = 0;
  string cur_req = "R1";

  vpipe_array dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [27:0] mcfg [5];
  logic [7:0]  mreg [3][4][2];
  bit          m_run, m_oval;
  int          m_step;
  logic [31:0] m_word, m_odata;

  function automatic logic [7:0] alu_ref(input int op, input logic [7:0] a, input logic [7:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return a << b[2:0];
      6: return a >> b[2:0];
      default: return a;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_oval = 0; m_step = 0; m_word = 0; m_odata = 0;
      for (int s = 0; s < 5; s++) mcfg[s] = '0;
      for (int s = 0; s < 3; s++) for (int p = 0; p < 4; p++) for (int r = 0; r < 2; r++) mreg[s][p][r] = '0;
    end else begin
      m_oval = 0;
      if (!m_run) begin
        if (cfg_we && cfg_addr < 5) mcfg[cfg_addr] = cfg_data;
        if (in_valid) begin m_run = 1; m_step = 0; end
      end else if (!(m_step == 1 && !in_valid)) begin
        if (m_step >= 1) begin
          int k, st;
          logic [31:0] src, nxt;
          k = m_step - 1;
          st = k % 3;
          src = (k == 0) ? in_data : m_word;
          nxt = '0;
          for (int p = 0; p < 4; p++) begin
            logic [6:0] c;
            logic [7:0] a, b, r;
            c = mcfg[k][p*7 +: 7];
            a = c[3] ? mreg[st][p][c[5]] : src[p*8 +: 8];
            b = c[4] ? mreg[st][p][c[5]] : src[((p+1)%4)*8 +: 8];
            r = alu_ref(int'(c[2:0]), a, b);
            nxt[p*8 +: 8] = r;
            if (c[6]) mreg[st][p][c[5]] = r;
          end
          m_word = nxt;
        end
        if (m_step == 5) begin m_run = 0; m_oval = 1; m_odata = m_word; end
        m_step++;
      end
    end
  end

  // cycle-by-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(in_ready == (m_run && m_step == 1), cur_req, {31'd0, in_ready}, {31'd0, (m_run && m_step == 1)});
      check(out_valid == m_oval, cur_req, {31'd0, out_valid}, {31'd0, m_oval});
      check(out_data == (m_oval ? m_odata : 32'd0), cur_req, out_data, m_oval ? m_odata : 32'd0);
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [6:0] pe(input int op, input bit sa, input bit sb, input bit rs, input bit we);
    return {we, rs, sb, sa, op[2:0]};
  endfunction

  task automatic write_cfg(input int stage, input logic [27:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = stage[2:0]; cfg_data = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_out(output logic [31:0] res);
    int n = 0;
    while (!out_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(n == 4, "R8 latency", n, 4);
    res = out_data;
    @(negedge clk);
    check(!out_valid, "R8 pulse width", {31'd0, out_valid}, 0);
  endtask

  task automatic run_word(input logic [31:0] d, input int stall, output logic [31:0] res);
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    if (stall > 0) begin
      @(negedge clk);
      in_valid = 1'b0;
      do @(negedge clk); while (!in_ready);
      for (int j = 0; j < stall; j++) begin
        @(negedge clk);
        check(in_ready, "R3 stall hold", {31'd0, in_ready}, 1);
      end
      in_valid = 1'b1;
    end else begin
      do @(negedge clk); while (!in_ready);
    end
    @(negedge clk);
    in_valid = 1'b0;
    wait_out(res);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r, r1;
    logic [6:0]  ps;
    rst_n = 1'b0; in_valid = 1'b0; cfg_we = 1'b0; in_data = '0; cfg_addr = '0; cfg_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!in_ready,  "R1 reset ready",  {31'd0, in_ready}, 0);
    check(!out_valid, "R1 reset valid",  {31'd0, out_valid}, 0);
    check(out_data == 0, "R1 reset data", out_data, 0);

    // R1/R9: zeroed configuration doubles each lane in every stage
    cur_req = "R1";
    run_word(32'h01010101, 0, r);
    check(r == 32'h20202020, "R1 R9 default chain", r, 32'h20202020);

    // R4/R5: subtract against the neighbour lane, then pass stages
    cur_req = "R5";
    ps = pe(7, 0, 0, 0, 0);
    write_cfg(0, {4{pe(1, 0, 0, 0, 0)}});
    for (int s = 1; s < 5; s++) write_cfg(s, {4{ps}});
    run_word(32'h04030201, 0, r);
    check(r == 32'h03FFFFFF, "R4 R5 sub neighbour", r, 32'h03FFFFFF);

    // R4: every opcode in a middle stage, compared to the model
    cur_req = "R4";
    for (int op = 0; op < 8; op++) begin
      write_cfg(2, {4{pe(op, 0, 0, 0, 0)}});
      run_word(32'hA53C0F81, 0, r);
    end
    write_cfg(2, {4{ps}});
    write_cfg(0, {4{ps}});
    run_word(32'h04030201, 0, r);
    check(r == 32'h04030201, "R4 pass", r, 32'h04030201);

    // R7: stage 0 writes a stripe-0 register, stage 3 reads it back
    cur_req = "R7";
    write_cfg(0, {ps, ps, ps, pe(7, 0, 0, 0, 1)});
    write_cfg(3, {ps, ps, ps, pe(0, 1, 0, 0, 0)});
    run_word(32'h04030201, 0, r);
    check(r == 32'h04030203, "R7 rotation shares registers", r, 32'h04030203);

    // R6: register persists when no later write happens
    cur_req = "R6";
    write_cfg(0, {4{ps}});
    run_word(32'h10101010, 0, r1);
    check(r1 == 32'h10101011, "R6 register persists", r1, 32'h10101011);

    // R2: a configuration write during a pass is ignored
    cur_req = "R2";
    @(negedge clk);
    in_valid = 1'b1; in_data = 32'h10101010;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd3; cfg_data = {4{pe(1, 0, 0, 0, 0)}};
    @(negedge clk);
    cfg_we = 1'b0;
    check(in_ready, "R3 ready after load", {31'd0, in_ready}, 1);
    @(negedge clk);
    in_valid = 1'b0;
    wait_out(r);
    check(r == r1, "R2 busy write same pass", r, r1);
    run_word(32'h10101010, 0, r);
    check(r == r1, "R2 busy write ignored", r, r1);

    // R3: stall with in_valid low while stage 0 waits
    cur_req = "R3";
    run_word(32'h01020344, 3, r);
    check(r == 32'h01020304, "R3 stalled pass result", r, 32'h01020304);
    @(negedge clk);
    check(!in_ready, "R3 idle not ready", {31'd0, in_ready}, 0);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule